// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block collects interrupt requests from a small group of external pins and merges them into one request line for a processor. Each pin has its own sensing edge, which can be rising or falling. Each pin also has a sticky request flag and its own enable bit. The pins may be asynchronous to the block clock. Every pin passes through a two-stage synchronizer before its edge is detected.

Software works with three byte-wide registers on a simple write-strobe and combinational-read port:

- an edge-select register,
- an enable register,
- a request-flag register.

A flag is set only by its sensing edge. Software can only clear it, by writing zero to its bit. A flag records an edge even while its source is disabled. The enable bit is applied only when the combined request is formed.

A global mask input blocks the request toward the processor. The block reports the index of the pending source with the highest priority, and the lowest-numbered source wins.

Top module: `ext_irq_ctrl`

## Requirements
- R1: For each source, edge-select bit 0 senses falling edges and 1 senses rising edges. A transition in the other direction does not set the flag.
- R2: A selected edge on a pin sets the flag of that pin. The flag reads 1 from the third rising clock edge after the pin changes, because of two synchronizer stages and one flag register.
- R3: Writing 0 to a flag bit clears it. Writing 1 to a flag bit has no effect, so software can never set a flag.
- R4: If a selected edge and a clearing write reach the same flag in the same clock cycle, the flag stays set.
- R5: A flag is set by its selected edge even when the enable bit of that source is 0.
- R6: irq_o is 1 exactly when at least one source has both its flag and its enable bit at 1 and glob_mask_i is 0.
- R7: irq_id_o gives the lowest source index whose flag and enable bit are both 1. It is 0 when no such source exists.
- R8: Address 0 selects the edge-select register, address 1 the enable register and address 2 the flag register. Address 3 reads 0x00 and ignores writes. All three registers reset to 0x00.
- R9: Register bits at positions N_SRC to 7 are reserved. They read as 0 and ignore writes. The default N_SRC is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | N_SRC | External interrupt pins, asynchronous to clk_i |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Write strobe, acts on the rising clock edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| glob_mask_i | input | 1 | Global mask; 1 blocks irq_o |
| irq_o | output | 1 | Combined masked request |
| irq_id_o | output | ID_W | Index of the highest-priority pending source |

## Verification
Two functions can act on the same flag in the same cycle: a sensing edge that sets it and a software write that clears it. The bench changes a pin so that the synchronized edge reaches the flag register on exactly the clock edge that applies a zero write to the flag register. It then reads the flags back. The colliding bit must remain set, and the other bits written with zero must be cleared.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SEL  = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  input  logic [WIDTH-1:0] rise_sel_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // 1 selects rising, 0 selects falling
    assign hit_o[i] = rise_sel_i[i] ? (lvl_i[i] & ~prev_q[i])
                                    : (~lvl_i[i] & prev_q[i]);
  end
endmodule

// File: rtl/ext_irq_prio.sv
module ext_irq_prio #(
  parameter int unsigned WIDTH = 6,
  localparam int unsigned ID_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req_i,
  output logic             any_o,
  output logic [ID_W-1:0]  id_o
);
  always_comb begin
    id_o = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_SRC = 6,
  localparam int unsigned ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  pin_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              glob_mask_i,
  output logic              irq_o,
  output logic [ID_W-1:0]   irq_id_o
);
  logic [N_SRC-1:0] pin_s;
  logic [N_SRC-1:0] hit;
  logic [N_SRC-1:0] sel_q, en_q, flag_q, flag_d;
  logic [N_SRC-1:0] wfield;
  logic [N_SRC-1:0] pend;
  logic             any_pend;
  logic             wr_sel, wr_en, wr_flag;

  ext_irq_sync #(.WIDTH(N_SRC), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  ext_irq_edge #(.WIDTH(N_SRC)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (pin_s),
    .rise_sel_i(sel_q),
    .hit_o     (hit)
  );

  assign wfield  = reg_wdata_i[N_SRC-1:0];
  assign wr_sel  = reg_we_i && (reg_addr_i == ADDR_SEL);
  assign wr_en   = reg_we_i && (reg_addr_i == ADDR_EN);
  assign wr_flag = reg_we_i && (reg_addr_i == ADDR_FLAG);

  // clear-only write; an edge in the same cycle overrides the clear
  assign flag_d = (wr_flag ? (flag_q & wfield) : flag_q) | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wr_sel) sel_q <= wfield;
      if (wr_en)  en_q  <= wfield;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_SEL:  reg_rdata_o[N_SRC-1:0] = sel_q;
      ADDR_EN:   reg_rdata_o[N_SRC-1:0] = en_q;
      ADDR_FLAG: reg_rdata_o[N_SRC-1:0] = flag_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign pend = flag_q & en_q;

  ext_irq_prio #(.WIDTH(N_SRC)) u_prio (
    .req_i(pend),
    .any_o(any_pend),
    .id_o (irq_id_o)
  );

  assign irq_o = any_pend & ~glob_mask_i;
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
  parameter int unsigned N_SRC = 6,
  localparam int unsigned ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             glob_mask_i,
  input logic             irq_o,
  input logic [ID_W-1:0]  irq_id_o,
  input logic [N_SRC-1:0] flag_i,
  input logic [N_SRC-1:0] en_i,
  input logic [N_SRC-1:0] hit_i
);
  logic [N_SRC-1:0] below;
  always_comb begin
    below = '0;
    for (int i = 0; i < N_SRC; i++) if (ID_W'(i) < irq_id_o) below[i] = 1'b1;
  end

  a_r6_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_mask_i |-> !irq_o);

  a_r6_needs_enabled_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag_i & en_i) != '0));

  a_r7_id_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_i[irq_id_o] && en_i[irq_id_o]));

  a_r7_id_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((flag_i & en_i & below) == '0));

  a_r3_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_i & ~$past(flag_i) & ~$past(hit_i)) == '0));

  a_r4_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit_i) & ~flag_i) == '0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .glob_mask_i(glob_mask_i),
  .irq_o      (irq_o),
  .irq_id_o   (irq_id_o),
  .flag_i     (flag_q),
  .en_i       (en_q),
  .hit_i      (hit)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  localparam int unsigned N = 6;
  localparam int unsigned IW = $clog2(N);
  localparam logic [7:0] FMASK = 8'((1 << N) - 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin = '0;
  logic [1:0]    addr = '0;
  logic          we = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          gmask = 1'b0;
  logic          irq;
  logic [IW-1:0] irq_id;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;

  logic [N-1:0] m_sel = '0, m_en = '0, m_flag = '0;

  always #2 clk = ~clk;

  ext_irq_ctrl #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .glob_mask_i(gmask), .irq_o(irq), .irq_id_o(irq_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [N-1:0] hits(input logic [N-1:0] o, input logic [N-1:0] n,
                                        input logic [N-1:0] s);
    return ((n & ~o) & s) | ((~n & o) & ~s);
  endfunction

  function automatic logic [IW-1:0] exp_id(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return IW'(i);
    return '0;
  endfunction

  task automatic set_pins(input logic [N-1:0] nv);
    @(negedge clk);
    m_flag |= hits(pin, nv, m_sel);
    pin = nv;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    rd(2'd0, v); check({tag, " R8 sel"}, 32'(v), 32'(m_sel));
    rd(2'd1, v); check({tag, " R8 en"}, 32'(v), 32'(m_en));
    rd(2'd2, v); check({tag, " R2 flag"}, 32'(v), 32'(m_flag));
    check({tag, " R6 irq"}, 32'(irq), 32'(((m_flag & m_en) != '0) && !gmask));
    check({tag, " R7 id"}, 32'(irq_id), 32'(exp_id(m_flag & m_en)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset values and unmapped address
    check_all("reset");
    rd(2'd3, v); check("R8 addr3 reads zero", 32'(v), 32'h0);

    // R9 reserved bits ignore writes and read 0
    wr(2'd1, 8'hFF); m_en = '1;
    rd(2'd1, v); check("R9 reserved en bits", 32'(v), 32'(FMASK));
    wr(2'd3, 8'hFF);
    rd(2'd3, v); check("R8 addr3 ignores write", 32'(v), 32'h0);
    wr(2'd1, 8'h00); m_en = '0;

    // R1 falling default: a rise does not set, a fall does
    set_pins(6'b000001);
    rd(2'd2, v); check("R1 rise ignored when falling selected", 32'(v), 32'h0);
    set_pins(6'b000000);
    rd(2'd2, v); check("R1 falling edge sets flag / R5 while disabled", 32'(v), 32'h01);

    // R2 latency: flag appears on third rising edge after pin change
    wr(2'd0, 8'h02); m_sel = 6'b000010;
    @(negedge clk); pin = 6'b000010;
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); check("R2 flag not yet set after two edges", 32'(v), 32'h01);
    @(negedge clk);
    rd(2'd2, v); check("R2 flag set after third edge", 32'(v), 32'h03);
    m_flag = 6'b000011;

    // R3 writing 1 has no effect, writing 0 clears
    wr(2'd2, 8'hFF);
    rd(2'd2, v); check("R3 write ones keeps flags", 32'(v), 32'h03);
    wr(2'd2, 8'hFE); m_flag = 6'b000010;
    rd(2'd2, v); check("R3 write zero clears bit0", 32'(v), 32'h02);

    // R6/R7 enable, priority and mask
    wr(2'd1, 8'h3F); m_en = '1;
    check_all("prio");
    gmask = 1'b1; #1;
    check("R6 global mask blocks irq", 32'(irq), 32'h0);
    gmask = 1'b0;

    // R4 edge and clear in same cycle: rising on bit3 vs clear-all write
    wr(2'd0, 8'h0A); m_sel = 6'b001010;
    @(negedge clk); pin = 6'b001010;
    @(negedge clk);
    @(negedge clk); addr = 2'd2; wdata = 8'h00; we = 1'b1;
    @(negedge clk); we = 1'b0;
    m_flag = 6'b001000;
    rd(2'd2, v); check("R4 edge wins over clear", 32'(v), 32'h08);
    check_all("after collision");

    // random phase
    for (int it = 0; it < 150; it++) begin
      int unsigned op;
      logic [7:0] r;
      op = $urandom_range(0, 4);
      r = 8'($urandom);
      case (op)
        0: set_pins(r[N-1:0]);
        1: begin wr(2'd0, r); m_sel = r[N-1:0]; end
        2: begin wr(2'd1, r); m_en = r[N-1:0]; end
        3: begin wr(2'd2, r); m_flag &= r[N-1:0]; end
        default: begin @(negedge clk); gmask = r[0]; end
      endcase
      @(negedge clk);
      check_all($sformatf("rand%0d", it));
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule